// File: doc/BRIEF.md
# Three-Wire Addressed Register Loader

This block receives configuration words over a three-wire serial bus (select, data, clock) and stores them in a small bank of registers. A host pulls the select line low and clocks in one frame, most significant bit first. Each rising edge of the serial clock captures one bit. The frame carries a data field followed by a register address in its final bits. When the host raises the select line again, the addressed register takes the data field.

The bus pins are sampled by a system clock that must run at least four times faster than the serial clock. Each pin passes through a two-flop synchronizer and an edge detector. A frame whose bit count is not exact is dropped, and the block flags it. Every register drives its own slice of a parallel output bus. Each accepted write is also shown on a one-cycle strobe together with its address.

Top module: `tw_reg_loader`

## Requirements
- R1: A frame holds FRAME_BITS bits (default 16) sent most significant bit first. Frame bits [15:2] form the data field: the first bit sent lands in data bit 13 and the fourteenth bit sent lands in data bit 0.
- R2: The last ADDR_BITS bits of a frame (bits [1:0]) pick the register. Register k sits at `regs_o[k*14 +: 14]`. Only the addressed register changes, and no register changes in a cycle that follows a cycle without a write strobe.
- R3: While select is low, a bit is taken from the data line only on a rising serial-clock edge. A change of the data line while the serial clock is high has no effect.
- R4: The write happens only on the low-to-high transition of select. A complete frame followed by select staying low changes nothing.
- R5: While select is high, toggling the serial clock and data lines causes no write strobe, no frame error and no register change.
- R6: If the number of rising clock edges taken while select was low is not exactly FRAME_BITS, the rising edge of select raises `frame_err` for one cycle. No write strobe follows and no register changes.
- R7: The bit counter and the shift register clear on the falling edge of select, so a valid frame sent after a discarded one is written correctly.
- R8: After reset all registers read zero, and `wr_stb` and `frame_err` are low.
- R9: Each accepted frame gives a `wr_stb` pulse one cycle long, with the register number on `wr_addr`. The addressed register output shows the new value one system clock after the strobe cycle and holds its old value during that cycle.
- R10: `wr_stb` and `frame_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel_n | input | 1 | Serial select, active low; its rising edge commits the frame |
| bus_dat | input | 1 | Serial data line |
| bus_sck | input | 1 | Serial clock; bits are captured on its rising edge |
| wr_stb | output | 1 | One-cycle pulse for each committed write |
| wr_addr | output | ADDR_BITS (2) | Register number of the last committed write |
| frame_err | output | 1 | One-cycle pulse when a frame had the wrong bit count |
| regs_o | output | 2**ADDR_BITS*(FRAME_BITS-ADDR_BITS) (56) | Register contents, register k at bits [k*14 +: 14] |

## Verification
The bench builds the block with its default parameters: 16-bit frames, a 2-bit address and therefore four 14-bit registers. With these values every register can be written and read back at its own port slice. Frames of 15 and 17 bits can be sent to reach both sides of the exact-count rule. The serial clock runs at eight system clocks per bit, which keeps each half period a few cycles above the four-times minimum. This leaves room to change the data line in the middle of a high phase.

// File: rtl/twl_pkg.sv
`timescale 1ns/1ps
package twl_pkg;
  // synchronized view of one bus line with its edge pulses
  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } line_ev_t;
endpackage

// File: rtl/twl_line_sync.sv
`timescale 1ns/1ps
module twl_line_sync
  import twl_pkg::*;
#(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     din,
  output line_ev_t ev
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], din};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  always_comb begin
    ev.lvl  = sync_q[STAGES-1];
    ev.rise = sync_q[STAGES-1] & ~prev_q;
    ev.fall = ~sync_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/twl_frame_shift.sv
`timescale 1ns/1ps
module twl_frame_shift
  import twl_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int ADDR_BITS  = 2,
  localparam int DW = FRAME_BITS - ADDR_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  line_ev_t             sel_ev,
  input  line_ev_t             sck_ev,
  input  line_ev_t             dat_ev,
  output logic                 wr_stb,
  output logic [ADDR_BITS-1:0] wr_addr,
  output logic [DW-1:0]        wr_data,
  output logic                 frame_err
);
  localparam int CW = $clog2(FRAME_BITS + 2);
  localparam logic [CW-1:0] CNT_FULL = CW'(FRAME_BITS);
  localparam logic [CW-1:0] CNT_SAT  = CW'(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [CW-1:0]         cnt_q, cnt_d;
  logic                  stb_q, stb_d, err_q, err_d;
  logic [ADDR_BITS-1:0]  addr_q, addr_d;
  logic [DW-1:0]         data_q, data_d;
  logic                  take_bit, commit, reject;

  always_comb begin
    take_bit = sck_ev.rise & ~sel_ev.lvl;
    commit   = sel_ev.rise & (cnt_q == CNT_FULL);
    reject   = sel_ev.rise & (cnt_q != CNT_FULL);

    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (sel_ev.fall) begin
      sh_d  = '0;
      cnt_d = '0;
    end
    if (take_bit) begin
      sh_d = {sh_d[FRAME_BITS-2:0], dat_ev.lvl};
      if (cnt_d != CNT_SAT) cnt_d = cnt_d + 1'b1;
    end

    stb_d  = commit;
    err_d  = reject;
    addr_d = commit ? sh_q[ADDR_BITS-1:0]          : addr_q;
    data_d = commit ? sh_q[FRAME_BITS-1:ADDR_BITS] : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      stb_q  <= 1'b0;
      err_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      stb_q  <= stb_d;
      err_q  <= err_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign wr_stb    = stb_q;
  assign frame_err = err_q;
  assign wr_addr   = addr_q;
  assign wr_data   = data_q;
endmodule

// File: rtl/twl_reg_bank.sv
`timescale 1ns/1ps
module twl_reg_bank #(
  parameter int AW = 2,
  parameter int DW = 14,
  localparam int NR = 2 ** AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_stb,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  output logic [NR*DW-1:0] regs_o
);
  for (genvar g = 0; g < NR; g++) begin : g_reg
    logic [DW-1:0] val_q, val_d;
    logic          hit;

    always_comb begin
      hit   = wr_stb && (wr_addr == AW'(g));
      val_d = hit ? wr_data : val_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= val_d;
    end

    assign regs_o[g*DW +: DW] = val_q;
  end
endmodule

// File: rtl/tw_reg_loader.sv
`timescale 1ns/1ps
module tw_reg_loader
  import twl_pkg::*;
#(
  parameter int FRAME_BITS  = 16,
  parameter int ADDR_BITS   = 2,
  parameter int SYNC_STAGES = 2,
  localparam int DW = FRAME_BITS - ADDR_BITS,
  localparam int NR = 2 ** ADDR_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel_n,
  input  logic                 bus_dat,
  input  logic                 bus_sck,
  output logic                 wr_stb,
  output logic [ADDR_BITS-1:0] wr_addr,
  output logic                 frame_err,
  output logic [NR*DW-1:0]     regs_o
);
  logic [1:0]    rst_pipe_q;
  logic          rst_ns;
  line_ev_t      sel_ev, sck_ev, dat_ev;
  logic [DW-1:0] wr_data;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ns = rst_pipe_q[1];

  twl_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sel (
    .clk(clk), .rst_n(rst_ns), .din(bus_sel_n), .ev(sel_ev));
  twl_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck (
    .clk(clk), .rst_n(rst_ns), .din(bus_sck), .ev(sck_ev));
  twl_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_dat (
    .clk(clk), .rst_n(rst_ns), .din(bus_dat), .ev(dat_ev));

  twl_frame_shift #(.FRAME_BITS(FRAME_BITS), .ADDR_BITS(ADDR_BITS)) u_shift (
    .clk(clk), .rst_n(rst_ns), .sel_ev(sel_ev), .sck_ev(sck_ev), .dat_ev(dat_ev),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .frame_err(frame_err));

  twl_reg_bank #(.AW(ADDR_BITS), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_ns), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .regs_o(regs_o));
endmodule

// File: rtl/twl_checker.sv
`timescale 1ns/1ps
module twl_checker #(
  parameter int FRAME_BITS = 16,
  parameter int ADDR_BITS  = 2,
  localparam int DW = FRAME_BITS - ADDR_BITS,
  localparam int NR = 2 ** ADDR_BITS
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_stb,
  input logic [ADDR_BITS-1:0] wr_addr,
  input logic [DW-1:0]        wr_data,
  input logic                 frame_err,
  input logic [NR*DW-1:0]     regs_o
);
  logic                 seen_q;
  logic [ADDR_BITS-1:0] seen_addr_q;
  logic [DW-1:0]        seen_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q      <= 1'b0;
      seen_addr_q <= '0;
      seen_data_q <= '0;
    end else begin
      seen_q      <= wr_stb;
      seen_addr_q <= wr_addr;
      seen_data_q <= wr_data;
    end
  end

  p_stb_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && frame_err));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(regs_o));

  p_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (regs_o[int'(seen_addr_q)*DW +: DW] == seen_data_q));
endmodule

bind tw_reg_loader twl_checker #(.FRAME_BITS(FRAME_BITS), .ADDR_BITS(ADDR_BITS)) u_chk (
  .clk(clk), .rst_n(rst_ns), .wr_stb(wr_stb), .wr_addr(wr_addr),
  .wr_data(wr_data), .frame_err(frame_err), .regs_o(regs_o));

// File: tb/tb_tw_reg_loader.sv
`timescale 1ns/1ps
module tb_tw_reg_loader;
  localparam int FB   = 16;
  localparam int AB   = 2;
  localparam int DW   = FB - AB;
  localparam int NR   = 2 ** AB;
  localparam int HALF = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, bus_sel_n, bus_dat, bus_sck;
  logic wr_stb, frame_err;
  logic [AB-1:0] wr_addr;
  logic [NR*DW-1:0] regs_o;

  tw_reg_loader #(.FRAME_BITS(FB), .ADDR_BITS(AB)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .bus_dat(bus_dat),
    .bus_sck(bus_sck), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .frame_err(frame_err), .regs_o(regs_o));

  int total = 0;
  int bad = 0;
  int wd = 0;
  logic [DW-1:0] exp_r [NR];

  // output monitor, sampled on the falling system edge
  int stb_seen = 0, err_seen = 0, both_seen = 0;
  logic [AB-1:0] last_addr = '0;
  logic [DW-1:0] pre_val = '0, post_val = '0;
  logic pend = 1'b0;

  always @(negedge clk) begin
    if (pend) begin
      post_val = regs_o[int'(last_addr)*DW +: DW];
      pend = 1'b0;
    end
    if (wr_stb === 1'b1) begin
      stb_seen++;
      last_addr = wr_addr;
      pre_val = regs_o[int'(wr_addr)*DW +: DW];
      pend = 1'b1;
    end
    if (frame_err === 1'b1) err_seen++;
    if (wr_stb === 1'b1 && frame_err === 1'b1) both_seen++;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", wd);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_mon();
    stb_seen = 0; err_seen = 0;
  endtask

  task automatic sel_low();
    @(negedge clk);
    bus_sel_n = 1'b0;
    cyc(HALF);
  endtask

  task automatic shift_bits(input int n, input logic [31:0] v, input bit flip_high);
    for (int i = n - 1; i >= 0; i--) begin
      bus_dat = v[i];
      cyc(HALF);
      bus_sck = 1'b1;
      cyc(2);
      if (flip_high) bus_dat = ~v[i];
      cyc(HALF - 2);
      bus_sck = 1'b0;
    end
    cyc(HALF);
  endtask

  task automatic sel_high();
    bus_sel_n = 1'b1;
    cyc(12);
  endtask

  task automatic check_regs(input string tag);
    for (int r = 0; r < NR; r++)
      chk(tag, 32'(regs_o[r*DW +: DW]), 32'(exp_r[r]));
  endtask

  task automatic good_write(input string tag, input logic [AB-1:0] a,
                            input logic [DW-1:0] d, input bit flip_high);
    logic [DW-1:0] old;
    old = exp_r[a];
    clear_mon();
    sel_low();
    shift_bits(FB, {16'h0, d, a}, flip_high);
    sel_high();
    chk({tag, " R9 strobe count"}, stb_seen, 1);
    chk({tag, " R6 no error"}, err_seen, 0);
    chk({tag, " R2 address"}, 32'(last_addr), 32'(a));
    chk({tag, " R9 old value in strobe cycle"}, 32'(pre_val), 32'(old));
    chk({tag, " R9 new value next cycle"}, 32'(post_val), 32'(d));
    exp_r[a] = d;
    check_regs({tag, " R1 R2 register bank"});
  endtask

  task automatic test_reset();
    for (int r = 0; r < NR; r++) exp_r[r] = '0;
    check_regs("R8 registers zero");
    chk("R8 wr_stb low", 32'(wr_stb), 0);
    chk("R8 frame_err low", 32'(frame_err), 0);
  endtask

  task automatic test_write_all();
    for (int a = 0; a < NR; a++)
      good_write("R1 fill", AB'(a), DW'(14'h01A5 + a * 14'h0F13), 1'b0);
  endtask

  task automatic test_bit_order();
    good_write("R1 msb", 2'd2, 14'h2001, 1'b0);
    good_write("R1 lsb", 2'd1, 14'h0002, 1'b0);
  endtask

  task automatic test_hold_until_sel();
    clear_mon();
    sel_low();
    shift_bits(FB, {16'h0, 14'h1234, 2'd0}, 1'b0);
    cyc(20);
    chk("R4 no strobe before select rises", stb_seen, 0);
    check_regs("R4 unchanged before select rises");
    sel_high();
    chk("R4 strobe after select rises", stb_seen, 1);
    exp_r[0] = 14'h1234;
    check_regs("R4 written after select rises");
  endtask

  task automatic test_rise_only();
    good_write("R3 rising edge sampling", 2'd3, 14'h3C5A, 1'b1);
  endtask

  task automatic test_sel_high_ignored();
    clear_mon();
    for (int i = 0; i < 24; i++) begin
      bus_dat = i[0] ^ i[2];
      cyc(HALF);
      bus_sck = 1'b1;
      cyc(HALF);
      bus_sck = 1'b0;
    end
    cyc(12);
    chk("R5 no strobe while select high", stb_seen, 0);
    chk("R5 no error while select high", err_seen, 0);
    check_regs("R5 registers unchanged");
  endtask

  task automatic test_bad_count();
    clear_mon();
    sel_low();
    shift_bits(FB - 1, {17'h0, 14'h0555, 1'b1}, 1'b0);
    sel_high();
    chk("R6 short frame error", err_seen, 1);
    chk("R6 short frame no strobe", stb_seen, 0);
    check_regs("R6 short frame registers unchanged");
    clear_mon();
    sel_low();
    shift_bits(FB + 1, {15'h0, 1'b1, 14'h2AAA, 2'd1}, 1'b0);
    sel_high();
    chk("R6 long frame error", err_seen, 1);
    chk("R6 long frame no strobe", stb_seen, 0);
    check_regs("R6 long frame registers unchanged");
    good_write("R7 valid frame after discard", 2'd1, 14'h1E0F, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    bus_sel_n = 1'b1;
    bus_sck = 1'b0;
    bus_dat = 1'b0;
    cyc(5);
    rst_n = 1'b1;
    cyc(6);
    test_reset();
    test_write_all();
    test_bit_order();
    test_hold_until_sel();
    test_rise_only();
    test_sel_high_ignored();
    test_bad_count();
    chk("R10 strobe and error never together", both_seen, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule